// File: doc/BRIEF.md
# Fracturable Pre-Adder and Post-ALU Stage

This block holds the adder and logic stages that sit in front of and behind a multiplier in an arithmetic tile. Two 16-bit pre-adders combine operand pairs before they reach the multiplier. A 36-bit post-ALU takes the multiplier product and a second operand. It adds, subtracts, shifts, applies bitwise logic, or adds the product into its own result register to form a multiply-accumulate. The multiplier is not part of this block. Its product enters on the ALU input port.

Two configuration bits, `mode` and `gate`, are the same bits that split the multiplier, and they may change on every cycle. With `mode` high, each pre-adder breaks its carry chain at the byte boundary, which gives four 8-bit add/subtract lanes. In the same setting the ALU breaks its carry and shift paths at bit 18, which gives two independent 18-bit lanes. With `gate` low and `mode` high, only the lower lanes are active and all upper lanes produce zero. Both stages are registered. The configuration applies to both stages in the cycle in which it is presented.

Top module: `frac_addalu`

## Requirements
- R1: While reset is asserted, and after it is released, `pre_x`, `pre_y` and `result` read zero until the first enabled update.
- R2: With `mode` low, pre-adder X registers `pa_a + pa_b`, or `pa_a - pa_b` when `pre_sub[0]` is 1, modulo 2^16, one cycle after the inputs are sampled. Pre-adder Y does the same with `pb_a`, `pb_b` and `pre_sub[2]`.
- R3: With `mode` high and `gate` high, each byte of `pre_x` and `pre_y` is computed on its own, modulo 256, with no carry crossing bit 8. `pre_sub` bit 0 selects subtract for the X low byte, bit 1 for the X high byte, bit 2 for the Y low byte, and bit 3 for the Y high byte.
- R4: With `mode` high and `gate` low, the lower byte lanes and the lower ALU lane behave as in R3 and R7. `pre_x[15:8]`, `pre_y[15:8]` and `result[35:18]` are registered as zero.
- R5: With `mode` low and `gate` low, the block behaves exactly as in full-width mode.
- R6: With `mode` low, opcode 000 registers `alu_x + alu_y` and opcode 001 registers `alu_x - alu_y`, both modulo 2^36.
- R7: With `mode` high, add and subtract work on two 18-bit lanes, bits 17:0 and bits 35:18. Each lane wraps on its own and no carry or borrow crosses bit 18.
- R8: Opcode 010 is a logical left shift and opcode 011 is a logical right shift, both of `alu_x`. In full mode the shift amount is `alu_y[3:0]` and bits move across the whole 36-bit word. With `mode` high, each lane shifts by its own amount, `alu_y[3:0]` for the low lane and `alu_y[21:18]` for the high lane, and no bits cross between lanes. Higher bits of the shift-amount field are ignored.
- R9: Opcodes 100, 101 and 110 register the bitwise AND, OR and XOR of `alu_x` and `alu_y`.
- R10: Opcode 111 registers `result + alu_x`. This wraps modulo 2^36 in full mode and per lane modulo 2^18 when `mode` is high.
- R11: A high `clr` zeroes `result` at the next edge, whether or not `en` is high. `clr` leaves the pre-adder registers unaffected.
- R12: While `en` is low and `clr` is low, all three output registers hold their values, whatever the other inputs do.
- R13: A change of `mode` or `gate` between consecutive cycles takes effect in the cycle in which it is presented, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Clock enable for all stage registers |
| clr | input | 1 | Synchronous clear of the result/accumulator register |
| mode | input | 1 | High splits carry chains into lanes |
| gate | input | 1 | With mode high, low disables the upper lanes |
| pa_a | input | 16 | Pre-adder X first operand |
| pa_b | input | 16 | Pre-adder X second operand |
| pb_a | input | 16 | Pre-adder Y first operand |
| pb_b | input | 16 | Pre-adder Y second operand |
| pre_sub | input | 4 | Per-lane subtract selects (see R2, R3) |
| op | input | 3 | ALU opcode |
| alu_x | input | 36 | ALU operand, normally the product |
| alu_y | input | 36 | ALU second operand / shift amounts |
| pre_x | output | 16 | Registered pre-adder X result |
| pre_y | output | 16 | Registered pre-adder Y result |
| result | output | 36 | Registered ALU result and accumulator |

## Verification
Pre-adder updates and ALU operations, including accumulation, happen in the same cycle, and a clear can land in that same cycle as an enabled update. The bench provokes this with random cycles in which `mode`, `gate`, the opcode, `en` and `clr` all change together. Each cycle both pre-adder outputs and the result are compared against a lane-wise model that tracks the accumulator on its own. Directed sequences add the cases that random stimulus rarely reaches: carries and shifted bits at the lane boundaries, accumulation that wraps within one lane, and a clear that coincides with an enabled update.

// File: rtl/frac_addalu_pkg.sv
package frac_addalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_SHL = 3'b010,
    OP_SHR = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_ACC = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic split;     // carry chains broken at lane boundaries
    logic upper_on;  // upper lanes produce results
  } lane_cfg_t;

  function automatic lane_cfg_t decode_cfg(input logic mode, input logic gate);
    lane_cfg_t c;
    c.split    = mode;
    c.upper_on = gate | ~mode;
    return c;
  endfunction

endpackage

// File: rtl/frac_slice_add.sv
module frac_slice_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  end

  assign s    = total[W-1:0];
  assign cout = total[W];
endmodule

// File: rtl/frac_preadd.sv
module frac_preadd #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic [LANE_W*LANES-1:0] a,
  input  logic [LANE_W*LANES-1:0] b,
  input  logic [LANES-1:0]        sub,
  input  logic                    split,
  input  logic                    upper_on,
  output logic [LANE_W*LANES-1:0] sum
);
  logic [LANES-1:0]             cout_l;
  logic [LANES-1:0][LANE_W-1:0] lane_s;
  logic                         unused_cout;

  assign unused_cout = cout_l[LANES-1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic              sub_k;
    logic              cin_k;
    logic [LANE_W-1:0] b_k;
    logic [LANE_W-1:0] s_k;

    assign sub_k = split ? sub[k] : sub[0];
    assign b_k   = sub_k ? ~b[k*LANE_W +: LANE_W] : b[k*LANE_W +: LANE_W];

    if (k == 0) begin : g_first
      assign cin_k = sub_k;
    end else begin : g_next
      assign cin_k = split ? sub_k : cout_l[k-1];
    end

    frac_slice_add #(.W(LANE_W)) u_add (
      .a    (a[k*LANE_W +: LANE_W]),
      .b    (b_k),
      .cin  (cin_k),
      .s    (s_k),
      .cout (cout_l[k])
    );

    if (k == 0) begin : g_keep
      assign lane_s[k] = s_k;
    end else begin : g_mask
      assign lane_s[k] = upper_on ? s_k : '0;
    end
  end

  assign sum = lane_s;
endmodule

// File: rtl/frac_alu.sv
module frac_alu
  import frac_addalu_pkg::*;
#(
  parameter int LANE_W  = 18,
  parameter int LANES   = 2,
  parameter int SHAMT_W = 4
) (
  input  logic [2:0]              op,
  input  logic [LANE_W*LANES-1:0] x,
  input  logic [LANE_W*LANES-1:0] y,
  input  logic [LANE_W*LANES-1:0] acc,
  input  logic                    split,
  input  logic                    upper_on,
  output logic [LANE_W*LANES-1:0] r
);
  localparam int AW = LANE_W * LANES;

  alu_op_e                      opc;
  logic                         sub_op;
  logic [AW-1:0]                add_a;
  logic [AW-1:0]                add_b;
  logic [AW-1:0]                shl_full;
  logic [AW-1:0]                shr_full;
  logic [LANES-1:0]             cout_l;
  logic [LANES-1:0][LANE_W-1:0] lane_r;
  logic                         unused_cout;

  assign unused_cout = cout_l[LANES-1];

  always_comb begin
    opc      = alu_op_e'(op);
    sub_op   = (opc == OP_SUB);
    add_a    = (opc == OP_ACC) ? acc : x;
    add_b    = (opc == OP_ACC) ? x : (sub_op ? ~y : y);
    shl_full = x << y[SHAMT_W-1:0];
    shr_full = x >> y[SHAMT_W-1:0];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic               cin_k;
    logic [LANE_W-1:0]  sum_k;
    logic [LANE_W-1:0]  x_k;
    logic [LANE_W-1:0]  y_k;
    logic [SHAMT_W-1:0] sh_k;
    logic [LANE_W-1:0]  shl_k;
    logic [LANE_W-1:0]  shr_k;
    logic [LANE_W-1:0]  res_k;

    assign x_k  = x[k*LANE_W +: LANE_W];
    assign y_k  = y[k*LANE_W +: LANE_W];
    assign sh_k = y_k[SHAMT_W-1:0];

    if (k == 0) begin : g_first
      assign cin_k = sub_op;
    end else begin : g_next
      assign cin_k = split ? sub_op : cout_l[k-1];
    end

    frac_slice_add #(.W(LANE_W)) u_add (
      .a    (add_a[k*LANE_W +: LANE_W]),
      .b    (add_b[k*LANE_W +: LANE_W]),
      .cin  (cin_k),
      .s    (sum_k),
      .cout (cout_l[k])
    );

    always_comb begin
      shl_k = split ? (x_k << sh_k) : shl_full[k*LANE_W +: LANE_W];
      shr_k = split ? (x_k >> sh_k) : shr_full[k*LANE_W +: LANE_W];
      unique case (opc)
        OP_ADD, OP_SUB, OP_ACC: res_k = sum_k;
        OP_SHL:                 res_k = shl_k;
        OP_SHR:                 res_k = shr_k;
        OP_AND:                 res_k = x_k & y_k;
        OP_OR:                  res_k = x_k | y_k;
        default:                res_k = x_k ^ y_k;
      endcase
    end

    if (k == 0) begin : g_keep
      assign lane_r[k] = res_k;
    end else begin : g_mask
      assign lane_r[k] = upper_on ? res_k : '0;
    end
  end

  assign r = lane_r;
endmodule

// File: rtl/frac_addalu.sv
module frac_addalu
  import frac_addalu_pkg::*;
#(
  parameter int PRE_LANE_W = 8,
  parameter int ALU_LANE_W = 18,
  parameter int SHAMT_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clr,
  input  logic                    mode,
  input  logic                    gate,
  input  logic [2*PRE_LANE_W-1:0] pa_a,
  input  logic [2*PRE_LANE_W-1:0] pa_b,
  input  logic [2*PRE_LANE_W-1:0] pb_a,
  input  logic [2*PRE_LANE_W-1:0] pb_b,
  input  logic [3:0]              pre_sub,
  input  logic [2:0]              op,
  input  logic [2*ALU_LANE_W-1:0] alu_x,
  input  logic [2*ALU_LANE_W-1:0] alu_y,
  output logic [2*PRE_LANE_W-1:0] pre_x,
  output logic [2*PRE_LANE_W-1:0] pre_y,
  output logic [2*ALU_LANE_W-1:0] result
);
  localparam int PW = 2 * PRE_LANE_W;
  localparam int AW = 2 * ALU_LANE_W;

  lane_cfg_t     cfg;
  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic [PW-1:0] px_sum, py_sum;
  logic [AW-1:0] alu_r;
  logic [PW-1:0] px_d, px_q, py_d, py_q;
  logic [AW-1:0] res_d, res_q;

  assign cfg = decode_cfg(mode, gate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  frac_preadd #(.LANE_W(PRE_LANE_W), .LANES(2)) u_pre_x (
    .a(pa_a), .b(pa_b), .sub(pre_sub[1:0]),
    .split(cfg.split), .upper_on(cfg.upper_on), .sum(px_sum)
  );

  frac_preadd #(.LANE_W(PRE_LANE_W), .LANES(2)) u_pre_y (
    .a(pb_a), .b(pb_b), .sub(pre_sub[3:2]),
    .split(cfg.split), .upper_on(cfg.upper_on), .sum(py_sum)
  );

  frac_alu #(.LANE_W(ALU_LANE_W), .LANES(2), .SHAMT_W(SHAMT_W)) u_alu (
    .op(op), .x(alu_x), .y(alu_y), .acc(res_q),
    .split(cfg.split), .upper_on(cfg.upper_on), .r(alu_r)
  );

  always_comb begin
    px_d  = en ? px_sum : px_q;
    py_d  = en ? py_sum : py_q;
    res_d = clr ? '0 : (en ? alu_r : res_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      px_q  <= '0;
      py_q  <= '0;
      res_q <= '0;
    end else begin
      px_q  <= px_d;
      py_q  <= py_d;
      res_q <= res_d;
    end
  end

  assign pre_x  = px_q;
  assign pre_y  = py_q;
  assign result = res_q;

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr |=> (result == '0));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en && !clr) |=> ($stable(result) && $stable(pre_x) && $stable(pre_y)));

  // R4
  upper_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && !clr && mode && !gate) |=>
      (result[AW-1:ALU_LANE_W] == '0 && pre_x[PW-1:PRE_LANE_W] == '0 &&
       pre_y[PW-1:PRE_LANE_W] == '0));

  // R10
  lane_acc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && !clr && mode && gate && op == 3'b111) |=>
      (result[AW-1:ALU_LANE_W] ==
       $past(result[AW-1:ALU_LANE_W] + alu_x[AW-1:ALU_LANE_W])));
endmodule

// File: tb/frac_addalu_tb.sv
module frac_addalu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, clr, mode, gate;
  logic [15:0] pa_a, pa_b, pb_a, pb_b;
  logic [3:0]  pre_sub;
  logic [2:0]  op;
  logic [35:0] alu_x, alu_y;
  logic [15:0] pre_x, pre_y;
  logic [35:0] result;

  logic [35:0] e_res;
  logic [15:0] e_px, e_py;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  frac_addalu u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .mode(mode), .gate(gate),
    .pa_a(pa_a), .pa_b(pa_b), .pb_a(pb_a), .pb_b(pb_b), .pre_sub(pre_sub),
    .op(op), .alu_x(alu_x), .alu_y(alu_y),
    .pre_x(pre_x), .pre_y(pre_y), .result(result)
  );

  // fields: mode, gate, op, x, y, expected result
  localparam int NV = 13;
  localparam logic [112:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'b000, 36'h00003FFFF, 36'h000000001, 36'h000040000}, // R6 carry over bit 18
    {1'b1, 1'b1, 3'b000, 36'h00003FFFF, 36'h000000001, 36'h000000000}, // R7 lane wrap
    {1'b0, 1'b1, 3'b001, 36'h000040000, 36'h000000001, 36'h00003FFFF}, // R6 borrow
    {1'b1, 1'b1, 3'b001, 36'h000040000, 36'h000000001, 36'h00007FFFF}, // R7 no borrow across
    {1'b0, 1'b1, 3'b010, 36'h000020000, 36'h000000001, 36'h000040000}, // R8 shl crosses
    {1'b1, 1'b1, 3'b010, 36'h000020000, 36'h000000001, 36'h000000000}, // R8 shl lane drop
    {1'b0, 1'b1, 3'b011, 36'h000040000, 36'h000040001, 36'h000020000}, // R8 shr crosses
    {1'b1, 1'b1, 3'b011, 36'h000040000, 36'h000040001, 36'h000000000}, // R8 shr lane drop
    {1'b0, 1'b1, 3'b100, 36'hFFFFFFFFF, 36'h123456789, 36'h123456789}, // R9 and
    {1'b1, 1'b1, 3'b110, 36'hFFFFFFFFF, 36'h0F0F0F0F0, 36'hF0F0F0F0F}, // R9 xor
    {1'b1, 1'b0, 3'b000, 36'h000050002, 36'h000010003, 36'h000020005}, // R4 upper gated
    {1'b0, 1'b0, 3'b000, 36'h00003FFFF, 36'h000000001, 36'h000040000}, // R5 full behaviour
    {1'b0, 1'b1, 3'b010, 36'h000000001, 36'h00000001F, 36'h000008000}  // R8 amount bit 4 ignored
  };

  function automatic logic [35:0] m_alu(input logic md, input logic gt, input logic [2:0] o,
                                        input logic [35:0] x, input logic [35:0] y,
                                        input logic [35:0] acc);
    logic [35:0] r;
    logic [17:0] xl, yl, al, rl;
    r = '0;
    if (!md) begin
      case (o)
        3'd0: r = x + y;
        3'd1: r = x - y;
        3'd2: r = x << y[3:0];
        3'd3: r = x >> y[3:0];
        3'd4: r = x & y;
        3'd5: r = x | y;
        3'd6: r = x ^ y;
        default: r = acc + x;
      endcase
    end else begin
      for (int l = 0; l < 2; l++) begin
        xl = x[l*18 +: 18];
        yl = y[l*18 +: 18];
        al = acc[l*18 +: 18];
        case (o)
          3'd0: rl = xl + yl;
          3'd1: rl = xl - yl;
          3'd2: rl = xl << yl[3:0];
          3'd3: rl = xl >> yl[3:0];
          3'd4: rl = xl & yl;
          3'd5: rl = xl | yl;
          3'd6: rl = xl ^ yl;
          default: rl = al + xl;
        endcase
        if (l == 1 && !gt) rl = '0;
        r[l*18 +: 18] = rl;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] m_pre(input logic md, input logic gt, input logic [15:0] a,
                                        input logic [15:0] b, input logic [1:0] s);
    logic [7:0] lo, hi;
    if (!md) return s[0] ? a - b : a + b;
    lo = s[0] ? a[7:0] - b[7:0] : a[7:0] + b[7:0];
    hi = s[1] ? a[15:8] - b[15:8] : a[15:8] + b[15:8];
    if (!gt) hi = '0;
    return {hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic md, input logic gt, input logic e, input logic c,
                      input logic [2:0] o, input logic [35:0] x, input logic [35:0] y,
                      input logic [15:0] a0, input logic [15:0] b0,
                      input logic [15:0] a1, input logic [15:0] b1, input logic [3:0] s);
    mode = md; gate = gt; en = e; clr = c; op = o; alu_x = x; alu_y = y;
    pa_a = a0; pa_b = b0; pb_a = a1; pb_b = b1; pre_sub = s;
    if (e) begin
      e_px = m_pre(md, gt, a0, b0, s[1:0]);
      e_py = m_pre(md, gt, a1, b1, s[3:2]);
    end
    e_res = c ? '0 : (e ? m_alu(md, gt, o, x, y, e_res) : e_res);
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en = 0; clr = 0; mode = 0; gate = 1; op = 0; alu_x = 0; alu_y = 0;
    pa_a = 0; pa_b = 0; pb_a = 0; pb_b = 0; pre_sub = 0;
    e_res = '0; e_px = '0; e_py = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 result in reset", result, 36'h0);
    chk("R1 pre_x in reset", {20'h0, pre_x}, 36'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 result after release", result, 36'h0);
    chk("R1 pre_y after release", {20'h0, pre_y}, 36'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][112], VEC[i][111], 1'b1, 1'b0, VEC[i][110:108], VEC[i][107:72],
           VEC[i][71:36], 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
      chk($sformatf("R6-table row %0d", i), result, VEC[i][35:0]);
    end

    // pre-adder directed
    step(0, 1, 1, 0, 3'd0, 36'h0, 36'h0, 16'h00FF, 16'h0001, 16'h0100, 16'h0001, 4'b0100);
    chk("R2 full add X", {20'h0, pre_x}, 36'h0100);
    chk("R2 full sub Y", {20'h0, pre_y}, 36'h00FF);
    step(1, 1, 1, 0, 3'd0, 36'h0, 36'h0, 16'h00FF, 16'h0001, 16'h0100, 16'h0001, 4'b1100);
    chk("R3 split add X", {20'h0, pre_x}, 36'h0000);
    chk("R3 split sub Y", {20'h0, pre_y}, 36'h01FF);
    step(1, 1, 1, 0, 3'd0, 36'h0, 36'h0, 16'h1234, 16'h1111, 16'h1020, 16'h0130, 4'b0100);
    chk("R3 mixed lanes Y", {20'h0, pre_y}, 36'h11F0);
    step(1, 0, 1, 0, 3'd0, 36'h0, 36'h0, 16'h1234, 16'h1111, 16'hFFFF, 16'h0101, 4'b0000);
    chk("R4 single X", {20'h0, pre_x}, 36'h0045);
    chk("R4 single Y", {20'h0, pre_y}, 36'h0000);

    // accumulation with per-cycle mode changes
    step(0, 1, 1, 1, 3'd7, 36'h5, 36'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    chk("R11 clear", result, 36'h0);
    step(1, 1, 1, 0, 3'd7, 36'h00007FFFF, 36'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    chk("R10 split acc", result, 36'h00007FFFF);
    step(1, 1, 1, 0, 3'd7, 36'h000000001, 36'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    chk("R10 lane wrap", result, 36'h000040000);
    step(0, 1, 1, 0, 3'd7, 36'h00003FFFF, 36'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    chk("R13 full acc after split", result, 36'h00007FFFF);
    step(0, 1, 1, 0, 3'd7, 36'h000000001, 36'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    chk("R10 full carry", result, 36'h000080000);
    step(1, 0, 1, 0, 3'd7, 36'h000040001, 36'h0, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    chk("R13 single acc", result, 36'h000000001);

    // clear priority and enable hold
    step(0, 1, 1, 0, 3'd0, 36'h5, 36'h6, 16'h3, 16'h4, 16'h0, 16'h0, 4'h0);
    chk("R6 small add", result, 36'hB);
    step(0, 1, 1, 1, 3'd0, 36'h5, 36'h6, 16'h8, 16'h1, 16'h0, 16'h0, 4'h0);
    chk("R11 clr beats en", result, 36'h0);
    chk("R11 pre unaffected", {20'h0, pre_x}, 36'h9);
    step(0, 1, 1, 0, 3'd0, 36'h5, 36'h6, 16'h3, 16'h4, 16'h0, 16'h0, 4'h0);
    step(1, 1, 0, 0, 3'd1, 36'h77, 36'h1, 16'hAA, 16'h1, 16'h5, 16'h5, 4'hF);
    chk("R12 hold result", result, 36'hB);
    chk("R12 hold pre_x", {20'h0, pre_x}, 36'h7);
    step(0, 1, 0, 1, 3'd0, 36'h1, 36'h1, 16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    chk("R11 clr without en", result, 36'h0);

    // random cycles against the lane-wise model
    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 9) != 0),
           ($urandom_range(0, 19) == 0), 3'($urandom_range(0, 7)),
           {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)},
           16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 4'($urandom));
      chk("R13 random result", result, e_res);
      chk("R13 random pre_x", {20'h0, pre_x}, {20'h0, e_px});
      chk("R13 random pre_y", {20'h0, pre_y}, {20'h0, e_py});
    end

    summary();
    $finish;
  end
endmodule